// File: doc/BRIEF.md
# Vector Extension Control and Status Register Unit

This unit holds the architectural control and status state of a vector extension and serves it over a simple CSR port. A 12-bit address selects one of seven registers:

- the start index;
- the saturation flag;
- the rounding mode;
- a 3-bit fixed-point word that joins the rounding mode and the saturation flag;
- the active vector length;
- the vector type;
- the constant register length in bytes.

Reads are combinational from the address. A write lands on the next clock edge. The saturation flag and the rounding mode have no storage of their own: they are views of bits in the fixed-point word.

The vector length and vector type registers cannot be written through the CSR port. A separate update port loads them, for the logic that executes the length-setting instruction. The unit decodes the vector type register and drives these outputs:

- the element-width exponent;
- the signed group-multiplier exponent;
- the two policy bits;
- the illegal flag;
- an invalid flag for each reserved width or multiplier encoding.

A one-cycle dirty pulse follows every write to a writable register. The surrounding status logic uses it to set the vector-status field to Dirty and to set the summary dirty bit.

Top module: `vec_csr_unit`

## Requirements
- R1: Reads of 0x008, 0x009, 0x00A, 0x00F, 0xC20, 0xC21 and 0xC22 raise `rd_hit`. Any other address gives `rd_hit` = 0 and `rd_data` = 0.
- R2: The fixed-point word at 0x00F reads as {rounding mode in bits 2..1, saturation in bit 0}. Reads of 0x00F, 0x009 and 0x00A are zero-extended to XLEN.
- R3: A write to 0x009 sets the saturation flag from `wr_data[0]` and leaves the rounding mode unchanged.
- R4: A write to 0x00A sets the rounding mode from `wr_data[1:0]` and leaves the saturation flag unchanged.
- R5: A write to 0x00F sets the rounding mode from `wr_data[2:1]` and the saturation flag from `wr_data[0]`.
- R6: A write to 0x008 stores the low log2(VLEN) bits of `wr_data`, and a read returns that value zero-extended. With VLEN = 128 that is 7 bits.
- R7: A read of 0xC22 always returns VLEN/8, which is 16 by default.
- R8: The vector length and vector type registers reset to 0 and load only from `upd_en`. A CSR write to 0xC20, 0xC21, 0xC22 or to an unmapped address changes no state.
- R9: Element-width codes in vtype[5:3] of 000, 001, 010 and 011 give `sew_pow` 3, 4, 5 and 6. Codes 100 to 111 raise `sew_bad` and give `sew_pow` = 0.
- R10: Multiplier codes in vtype[2:0] of 101, 110, 111, 000, 001, 010 and 011 give `lmul_pow` -3, -2, -1, 0, 1, 2 and 3 in 4-bit two's complement. Code 100 raises `lmul_bad` and gives `lmul_pow` = 0.
- R11: `vma_agn` follows vtype[7], `vta_agn` follows vtype[6] and `vill` follows vtype[XLEN-1]. For each policy bit, 1 means agnostic and 0 means undisturbed.
- R12: `dirty_pulse` is high for exactly the one cycle after a write to 0x008, 0x009, 0x00A or 0x00F. It stays low after any other write.
- R13: After reset, the start index, the rounding mode and the saturation flag are 0 and `dirty_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address for reads and writes |
| wr_en | input | 1 | Write strobe for the address on `csr_addr` |
| wr_data | input | 16 | Write data; all writable fields lie in the low 16 bits |
| rd_data | output | XLEN | Combinational read data |
| rd_hit | output | 1 | Address is a mapped vector CSR |
| upd_en | input | 1 | Load strobe for vector length and type |
| upd_vl | input | XLEN | New vector length |
| upd_vtype | input | XLEN | New vector type |
| sew_pow | output | 3 | Element-width exponent |
| sew_bad | output | 1 | Reserved element-width code |
| lmul_pow | output | 4 | Signed multiplier exponent |
| lmul_bad | output | 1 | Reserved multiplier code |
| vta_agn | output | 1 | Tail policy is agnostic |
| vma_agn | output | 1 | Mask policy is agnostic |
| vill | output | 1 | Vector type illegal flag |
| dirty_pulse | output | 1 | Vector state was just written |

## Verification
The three fixed-point addresses show one shared 3-bit store from three angles. A wrong alias therefore shows up at once, in a read of another address made in the cycle after the write. For this reason the bench follows each partial write with reads of all three views.

A missing dirty pulse, or a spurious one, shows on `dirty_pulse` in the cycle just after the write. The decode flags are combinational from the type register, so a decode fault shows on the outputs in the cycle after an update.

// File: rtl/vec_csr_unit.sv
module vec_csr_unit #(
  parameter int XLEN = 64,
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            wr_en,
  input  logic [15:0]     wr_data,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_hit,
  input  logic            upd_en,
  input  logic [XLEN-1:0] upd_vl,
  input  logic [XLEN-1:0] upd_vtype,
  output logic [2:0]      sew_pow,
  output logic            sew_bad,
  output logic [3:0]      lmul_pow,
  output logic            lmul_bad,
  output logic            vta_agn,
  output logic            vma_agn,
  output logic            vill,
  output logic            dirty_pulse
);
  localparam int SW = $clog2(VLEN);
  localparam logic [11:0] A_START = 12'h008;
  localparam logic [11:0] A_SAT   = 12'h009;
  localparam logic [11:0] A_RND   = 12'h00A;
  localparam logic [11:0] A_FX    = 12'h00F;
  localparam logic [11:0] A_LEN   = 12'hC20;
  localparam logic [11:0] A_TYPE  = 12'hC21;
  localparam logic [11:0] A_BYTES = 12'hC22;

  logic [SW-1:0]   vstart_q;
  logic [1:0]      vxrm_q;
  logic            vxsat_q;
  logic [XLEN-1:0] vl_q;
  logic [XLEN-1:0] vtype_q;
  logic            dirty_q;

  wire w_start = wr_en && csr_addr == A_START;
  wire w_sat   = wr_en && csr_addr == A_SAT;
  wire w_rnd   = wr_en && csr_addr == A_RND;
  wire w_fx    = wr_en && csr_addr == A_FX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vstart_q <= '0;
      vxrm_q   <= '0;
      vxsat_q  <= 1'b0;
      vl_q     <= '0;
      vtype_q  <= '0;
      dirty_q  <= 1'b0;
    end else begin
      dirty_q <= w_start | w_sat | w_rnd | w_fx;
      if (w_start) vstart_q <= wr_data[SW-1:0];
      if (w_sat)   vxsat_q  <= wr_data[0];
      if (w_rnd)   vxrm_q   <= wr_data[1:0];
      if (w_fx)    {vxrm_q, vxsat_q} <= wr_data[2:0];
      if (upd_en) begin
        vl_q    <= upd_vl;
        vtype_q <= upd_vtype;
      end
    end
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (csr_addr)
      A_START: rd_data = XLEN'(vstart_q);
      A_SAT:   rd_data = XLEN'(vxsat_q);
      A_RND:   rd_data = XLEN'(vxrm_q);
      A_FX:    rd_data = XLEN'({vxrm_q, vxsat_q});
      A_LEN:   rd_data = vl_q;
      A_TYPE:  rd_data = vtype_q;
      A_BYTES: rd_data = XLEN'(VLEN / 8);
      default: rd_hit  = 1'b0;
    endcase
  end

  wire [2:0] sew_code  = vtype_q[5:3];
  wire [2:0] lmul_code = vtype_q[2:0];

  assign sew_bad     = sew_code[2];
  assign sew_pow     = sew_bad ? 3'd0 : 3'({1'b0, sew_code[1:0]}) + 3'd3;
  assign lmul_bad    = lmul_code == 3'b100;
  assign lmul_pow    = lmul_bad ? 4'd0 : {lmul_code[2], lmul_code};
  assign vma_agn     = vtype_q[7];
  assign vta_agn     = vtype_q[6];
  assign vill        = vtype_q[XLEN-1];
  assign dirty_pulse = dirty_q;
endmodule

module vec_csr_unit_chk #(
  parameter int XLEN = 64,
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     csr_addr,
  input logic            wr_en,
  input logic [XLEN-1:0] rd_data,
  input logic [2:0]      sew_pow,
  input logic            sew_bad,
  input logic [3:0]      lmul_pow,
  input logic            lmul_bad,
  input logic            dirty_pulse,
  input logic [1:0]      vxrm_q,
  input logic            vxsat_q
);
  // R12
  dirty_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_pulse |-> $past(wr_en));
  // R3
  sat_keeps_rnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && csr_addr == 12'h009) |=> vxrm_q == $past(vxrm_q));
  // R4
  rnd_keeps_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && csr_addr == 12'h00A) |=> vxsat_q == $past(vxsat_q));
  // R7
  bytes_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'hC22) |-> rd_data == XLEN'(VLEN / 8));
  // R2
  fx_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h00F) |-> rd_data[XLEN-1:3] == '0);
  // R8
  ro_no_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (csr_addr == 12'hC20 || csr_addr == 12'hC21)) |=> !dirty_pulse);
  // R9
  sew_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sew_bad |-> sew_pow == 3'd0);
  // R10
  lmul_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lmul_bad |-> lmul_pow == 4'd0);
endmodule

bind vec_csr_unit vec_csr_unit_chk #(.XLEN(XLEN), .VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .wr_en(wr_en),
  .rd_data(rd_data), .sew_pow(sew_pow), .sew_bad(sew_bad),
  .lmul_pow(lmul_pow), .lmul_bad(lmul_bad), .dirty_pulse(dirty_pulse),
  .vxrm_q(vxrm_q), .vxsat_q(vxsat_q)
);

// File: tb/vec_csr_unit_tb.sv
module vec_csr_unit_tb;
  localparam int XLEN = 64;
  localparam int VLEN = 128;
  localparam time CLK_PERIOD = 10;
  localparam int NV = 8;
  // {vtype[7:0], sew_pow[2:0], sew_bad, lmul_pow[3:0], lmul_bad}
  localparam logic [16:0] TBL [NV] = '{
    {8'h00, 3'd3, 1'b0, 4'd0,  1'b0},
    {8'h08, 3'd4, 1'b0, 4'd0,  1'b0},
    {8'h13, 3'd5, 1'b0, 4'd3,  1'b0},
    {8'h1D, 3'd6, 1'b0, 4'hD,  1'b0},
    {8'h06, 3'd3, 1'b0, 4'hE,  1'b0},
    {8'h07, 3'd3, 1'b0, 4'hF,  1'b0},
    {8'h24, 3'd0, 1'b1, 4'd0,  1'b1},
    {8'h3A, 3'd0, 1'b1, 4'd2,  1'b0}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, upd_en = 0;
  logic [11:0] csr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [XLEN-1:0] upd_vl = 0, upd_vtype = 0, rd_data;
  logic rd_hit, sew_bad, lmul_bad, vta_agn, vma_agn, vill, dirty_pulse;
  logic [2:0] sew_pow;
  logic [3:0] lmul_pow;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_csr_unit #(.XLEN(XLEN), .VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rd_hit(rd_hit),
    .upd_en(upd_en), .upd_vl(upd_vl), .upd_vtype(upd_vtype),
    .sew_pow(sew_pow), .sew_bad(sew_bad), .lmul_pow(lmul_pow),
    .lmul_bad(lmul_bad), .vta_agn(vta_agn), .vma_agn(vma_agn),
    .vill(vill), .dirty_pulse(dirty_pulse));

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, string tag, logic [XLEN-1:0] exp);
    csr_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d, string tag, logic exp_dirty);
    @(negedge clk);
    csr_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    #1;
    check(tag, {63'd0, dirty_pulse}, {63'd0, exp_dirty});
  endtask

  task automatic upd(logic [XLEN-1:0] l, logic [XLEN-1:0] t);
    @(negedge clk);
    upd_vl = l; upd_vtype = t; upd_en = 1;
    @(negedge clk);
    upd_en = 0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R13 reset state
    check("R13 dirty", {63'd0, dirty_pulse}, 0);
    rd(12'h008, "R13 start", 0);
    rd(12'h00F, "R13 fx", 0);
    // R8 reset of length and type
    rd(12'hC20, "R8 vl reset", 0);
    rd(12'hC21, "R8 vtype reset", 0);
    // R7
    rd(12'hC22, "R7 bytes", 16);
    // R1
    check("R1 hit", {63'd0, rd_hit}, 1);
    rd(12'h123, "R1 unmapped data", 0);
    check("R1 unmapped hit", {63'd0, rd_hit}, 0);

    // R9 R10 decode table
    for (int i = 0; i < NV; i++) begin
      upd(0, XLEN'(TBL[i][16:9]));
      check("R9 sew_pow", XLEN'(sew_pow), XLEN'(TBL[i][8:6]));
      check("R9 sew_bad", XLEN'(sew_bad), XLEN'(TBL[i][5]));
      check("R10 lmul_pow", XLEN'(lmul_pow), XLEN'(TBL[i][4:1]));
      check("R10 lmul_bad", XLEN'(lmul_bad), XLEN'(TBL[i][0]));
    end

    // R11 policy and illegal bits
    upd(64'h40, 64'h8000_0000_0000_0080);
    check("R11 vma", XLEN'(vma_agn), 1);
    check("R11 vta", XLEN'(vta_agn), 0);
    check("R11 vill", XLEN'(vill), 1);
    rd(12'hC20, "R8 vl load", 64'h40);
    upd(64'h41, 64'h40);
    check("R11 vma2", XLEN'(vma_agn), 0);
    check("R11 vta2", XLEN'(vta_agn), 1);
    check("R11 vill2", XLEN'(vill), 0);

    // R5 combined write
    wr(12'h00F, 16'hFFFD, "R12 dirty fx", 1);
    rd(12'h00F, "R5 fx", 5);
    rd(12'h009, "R2 sat view", 1);
    rd(12'h00A, "R2 rnd view", 2);
    // R4
    wr(12'h00A, 16'hFFF3, "R12 dirty rnd", 1);
    rd(12'h00F, "R4 fx", 7);
    // R3
    wr(12'h009, 16'hFFFE, "R12 dirty sat", 1);
    rd(12'h00F, "R3 fx", 6);
    rd(12'h009, "R3 sat", 0);
    rd(12'h00A, "R3 rnd", 3);
    #(CLK_PERIOD);
    check("R12 pulse one cycle", XLEN'(dirty_pulse), 0);

    // R6 start index truncation
    wr(12'h008, 16'hFFAB, "R12 dirty start", 1);
    rd(12'h008, "R6 start", 64'h2B);
    wr(12'h008, 16'h0080, "R12 dirty start2", 1);
    rd(12'h008, "R6 start wrap", 0);

    // R8 read-only and unmapped writes ignored
    wr(12'hC21, 16'hFFFF, "R12 no dirty vtype", 0);
    rd(12'hC21, "R8 vtype kept", 64'h40);
    wr(12'hC20, 16'h1234, "R12 no dirty vl", 0);
    rd(12'hC20, "R8 vl kept", 64'h41);
    wr(12'hC22, 16'h0001, "R12 no dirty bytes", 0);
    rd(12'hC22, "R7 bytes kept", 16);
    wr(12'h123, 16'h0007, "R12 no dirty unmapped", 0);
    rd(12'h00F, "R8 fx kept", 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule